// File: doc/BRIEF.md
# USB Device Global NAK Controller

This block holds the device control word of a high-speed USB device core and turns its global NAK commands into per-packet handshake decisions. Software reaches it through a small register bus with an address, write data, a write strobe and combinational read data. The word carries four write-only command bits that raise or drop a global OUT NAK and a global non-periodic IN NAK. It also carries two read-only status bits that mirror those conditions, a three-bit test-mode selector, and a flag that software sets once it has finished reprogramming the core after a wake from power-down.

Each global NAK condition is a two-state machine with the states `NAK_IDLE` and `NAK_ACTIVE`. A set command moves it from `NAK_IDLE` to `NAK_ACTIVE`. A clear command without a set moves it from `NAK_ACTIVE` back to `NAK_IDLE`. Every other case holds the state. When set and clear arrive in the same write, the set command wins.

For every received OUT or SETUP packet, the handshake stage registers one decision. It chooses among no handshake, ACK, NAK and STALL, and it decides whether the packet's data may enter the receive FIFO. The inputs to that decision are the global OUT NAK state, the free FIFO space, the endpoint type, and the endpoint's own NAK and STALL bits.

Top module: `usbd_gnak_ctrl`

## Requirements
- R1: After reset, reading the control offset 0x804 returns 0. Both NAK outputs, `prog_done` and `hs_valid` are 0, and `tmode_oh` equals 6'b000001.
- R2: A write to 0x804 with bit 9 set makes the global OUT NAK active from the next cycle. Both read bit 3 and `out_nak_active` then show 1.
- R3: A write to 0x804 with bit 10 set and bit 9 clear makes the global OUT NAK inactive. If bits 9 and 10 are both set in one write, the NAK becomes or stays active.
- R4: Write bits 7 and 8 set and clear the global IN NAK, with set winning over clear. The state shows on read bit 2 and on `in_nak_active`.
- R5: Command bits 10:7 and reserved bits 31:12 always read as 0. Writes to status bits 3:2 and to reserved bits have no effect. Writes to any other address change nothing, and reads from them return 0.
- R6: Bits 6:4 store and read back any written code. `tmode_oh` is one-hot with these bit positions:
  - bit k set for code k, for codes 1 to 5: 1 Test_J, 2 Test_K, 3 Test_SE0_NAK, 4 Test_Packet, 5 Test_Force_Enable.
  - bit 0 set for code 0 and for the reserved codes 6 and 7.
- R7: Bit 11 is a read-write flag that drives `prog_done`.
- R8: A packet presented with `pkt_valid` high at a clock edge gets its decision on `hs_valid`, `hs_code` and `fifo_wr_en` after that edge, for exactly one cycle. In cycles without a packet, `hs_valid` and `fifo_wr_en` are 0.
- R9: `hs_code` encoding: 0 none, 1 ACK, 2 NAK, 3 STALL. While the global OUT NAK is active, a non-isochronous OUT packet gets STALL if `ep_stall` is set and NAK otherwise, and `fifo_wr_en` is 0.
- R10: While the global OUT NAK is active, an isochronous OUT packet gets code 0 (no handshake) and its data is not written.
- R11: A SETUP packet gets ACK with `fifo_wr_en` = 1 whenever `pkt_len` <= `fifo_space`, regardless of the global NAK, `ep_stall` and `ep_nak`. Without room it gets NAK and no write.
- R12: While the global OUT NAK is inactive, a non-isochronous OUT packet is decided in this priority order:
  - STALL if `ep_stall` is set;
  - otherwise NAK if `ep_nak` is set or `pkt_len` > `fifo_space`;
  - otherwise ACK with a write.
  An isochronous OUT packet gets code 0 and is written when it fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pkt_valid | input | 1 | A received packet awaits a decision |
| pkt_setup | input | 1 | Packet is a SETUP transaction |
| pkt_iso | input | 1 | Packet targets an isochronous OUT endpoint |
| pkt_len | input | 11 | Packet payload size in bytes |
| fifo_space | input | 12 | Free receive FIFO space in bytes |
| ep_nak | input | 1 | Endpoint's own NAK setting |
| ep_stall | input | 1 | Endpoint's own STALL setting |
| hs_valid | output | 1 | Decision valid this cycle |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| fifo_wr_en | output | 1 | Packet data may be written to the FIFO |
| out_nak_active | output | 1 | Global OUT NAK state |
| in_nak_active | output | 1 | Global IN NAK state |
| tmode_oh | output | 6 | One-hot decoded test mode |
| prog_done | output | 1 | Power-on programming done flag |

## Verification
Register writes take effect at the edge on which the strobe is sampled. Read data and the state outputs reflect a write one edge after it, so the bench drops the strobe on the following falling edge and checks there. A packet decision is due one edge after `pkt_valid` is sampled. The bench therefore drives each packet on a falling edge, checks the decision at the next falling edge, and confirms one cycle later that `hs_valid` has dropped again. A change of global NAK is written in full before the packet that depends on it, so the decision always sees the settled state.

// File: rtl/usbd_gnak_pkg.sv
package usbd_gnak_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    typedef enum logic {
        NAK_IDLE   = 1'b0,
        NAK_ACTIVE = 1'b1
    } nak_state_e;

    // Field positions within the control word
    localparam int BIT_IN_STS    = 2;
    localparam int BIT_OUT_STS   = 3;
    localparam int TM_LSB        = 4;
    localparam int TM_W          = 3;
    localparam int BIT_IN_SET    = 7;
    localparam int BIT_IN_CLR    = 8;
    localparam int BIT_OUT_SET   = 9;
    localparam int BIT_OUT_CLR   = 10;
    localparam int BIT_PROG_DONE = 11;
    localparam int TM_MODES      = 6;

endpackage

// File: rtl/usbd_gnak_fsm.sv
module usbd_gnak_fsm
    import usbd_gnak_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    output logic active
);

    nak_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NAK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NAK_IDLE:   if (set_cmd)             state_d = NAK_ACTIVE;
            NAK_ACTIVE: if (clr_cmd && !set_cmd) state_d = NAK_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == NAK_ACTIVE);
    end

    // R3 / R4: set command wins and is seen next cycle
    a_r3_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_cmd |=> active);

    // R3 / R4: a lone clear drops the condition
    a_r3_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !set_cmd) |=> !active);

endmodule

// File: rtl/usbd_gnak_hshk.sv
module usbd_gnak_hshk
    import usbd_gnak_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int SPACE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_valid,
    input  logic               pkt_setup,
    input  logic               pkt_iso,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [SPACE_W-1:0] fifo_space,
    input  logic               ep_nak,
    input  logic               ep_stall,
    input  logic               gnak_out,
    output logic               hs_valid,
    output logic [1:0]         hs_code,
    output logic               fifo_wr_en
);

    localparam int CMP_W = (LEN_W > SPACE_W) ? LEN_W : SPACE_W;

    logic [CMP_W-1:0] len_ext, space_ext;
    logic             room;
    hs_code_e         code_d, code_q;
    logic             wr_d, wr_q, valid_q;

    always_comb begin
        len_ext   = CMP_W'(pkt_len);
        space_ext = CMP_W'(fifo_space);
        room      = (len_ext <= space_ext);
    end

    always_comb begin
        code_d = HS_NONE;
        wr_d   = 1'b0;
        if (pkt_setup) begin
            code_d = room ? HS_ACK : HS_NAK;
            wr_d   = room;
        end else if (pkt_iso) begin
            code_d = HS_NONE;
            wr_d   = !gnak_out && room;
        end else if (ep_stall) begin
            code_d = HS_STALL;
        end else if (gnak_out || ep_nak || !room) begin
            code_d = HS_NAK;
        end else begin
            code_d = HS_ACK;
            wr_d   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            code_q  <= HS_NONE;
            wr_q    <= 1'b0;
        end else begin
            valid_q <= pkt_valid;
            code_q  <= pkt_valid ? code_d : HS_NONE;
            wr_q    <= pkt_valid && wr_d;
        end
    end

    always_comb begin
        hs_valid   = valid_q;
        hs_code    = code_q;
        fifo_wr_en = wr_q;
    end

    // R8: decision follows the packet by one cycle
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> hs_valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> (!hs_valid && !fifo_wr_en));

    // R9: no FIFO write for non-SETUP packets under global OUT NAK
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && gnak_out && !pkt_setup) |=> !fifo_wr_en);

    // R10: isochronous drop under global OUT NAK
    a_r10_iso_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && gnak_out && pkt_iso && !pkt_setup) |=>
        (hs_code == 2'd0 && !fifo_wr_en));

    // R11: SETUP with room is acknowledged and written
    a_r11_setup_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_setup && (CMP_W'(pkt_len) <= CMP_W'(fifo_space))) |=>
        (hs_code == 2'd1 && fifo_wr_en));

endmodule

// File: rtl/usbd_gnak_tmode.sv
module usbd_gnak_tmode
    import usbd_gnak_pkg::*;
(
    input  logic [TM_W-1:0]     code,
    output logic [TM_MODES-1:0] oh
);

    // Position 0 also absorbs every reserved code
    always_comb begin
        oh[0] = (code == '0) || (int'(code) >= TM_MODES);
    end

    for (genvar k = 1; k < TM_MODES; k++) begin : g_mode
        always_comb begin
            oh[k] = (int'(code) == k);
        end
    end

endmodule

// File: rtl/usbd_gnak_ctrl.sv
module usbd_gnak_ctrl
    import usbd_gnak_pkg::*;
#(
    parameter int              ADDR_W      = 12,
    parameter int              DATA_W      = 32,
    parameter int              LEN_W       = 11,
    parameter int              SPACE_W     = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h804
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               pkt_valid,
    input  logic               pkt_setup,
    input  logic               pkt_iso,
    input  logic [LEN_W-1:0]   pkt_len,
    input  logic [SPACE_W-1:0] fifo_space,
    input  logic               ep_nak,
    input  logic               ep_stall,
    output logic               hs_valid,
    output logic [1:0]         hs_code,
    output logic               fifo_wr_en,
    output logic               out_nak_active,
    output logic               in_nak_active,
    output logic [TM_MODES-1:0] tmode_oh,
    output logic               prog_done
);

    logic            hit, wr_hit;
    logic [TM_W-1:0] tmode_q;
    logic            prog_done_q;
    logic            out_nak, in_nak;
    logic            unused_wdata;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:BIT_PROG_DONE+1], bus_wdata[BIT_OUT_STS:0]};

    always_comb begin
        hit    = (bus_addr == CTRL_OFFSET);
        wr_hit = bus_we && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmode_q     <= '0;
            prog_done_q <= 1'b0;
        end else if (wr_hit) begin
            tmode_q     <= bus_wdata[TM_LSB +: TM_W];
            prog_done_q <= bus_wdata[BIT_PROG_DONE];
        end
    end

    usbd_gnak_fsm u_out_nak (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (wr_hit && bus_wdata[BIT_OUT_SET]),
        .clr_cmd (wr_hit && bus_wdata[BIT_OUT_CLR]),
        .active  (out_nak)
    );

    usbd_gnak_fsm u_in_nak (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (wr_hit && bus_wdata[BIT_IN_SET]),
        .clr_cmd (wr_hit && bus_wdata[BIT_IN_CLR]),
        .active  (in_nak)
    );

    usbd_gnak_tmode u_tmode (
        .code (tmode_q),
        .oh   (tmode_oh)
    );

    usbd_gnak_hshk #(
        .LEN_W   (LEN_W),
        .SPACE_W (SPACE_W)
    ) u_hshk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_valid  (pkt_valid),
        .pkt_setup  (pkt_setup),
        .pkt_iso    (pkt_iso),
        .pkt_len    (pkt_len),
        .fifo_space (fifo_space),
        .ep_nak     (ep_nak),
        .ep_stall   (ep_stall),
        .gnak_out   (out_nak),
        .hs_valid   (hs_valid),
        .hs_code    (hs_code),
        .fifo_wr_en (fifo_wr_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_IN_STS]         = in_nak;
            bus_rdata[BIT_OUT_STS]        = out_nak;
            bus_rdata[TM_LSB +: TM_W]     = tmode_q;
            bus_rdata[BIT_PROG_DONE]      = prog_done_q;
        end
        out_nak_active = out_nak;
        in_nak_active  = in_nak;
        prog_done      = prog_done_q;
    end

    // R6: decoded test mode always names exactly one mode
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tmode_oh) == 1);

    // R7: flag follows a write to the control offset
    a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (prog_done == $past(bus_wdata[BIT_PROG_DONE])));

endmodule

// File: tb/usbd_gnak_ctrl_tb_top.sv
module usbd_gnak_ctrl_tb_top;

    localparam logic [11:0] CTRL = 12'h804;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = CTRL;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        pkt_valid = 1'b0, pkt_setup = 1'b0, pkt_iso = 1'b0;
    logic [10:0] pkt_len = '0;
    logic [11:0] fifo_space = 12'd64;
    logic        ep_nak = 1'b0, ep_stall = 1'b0;
    logic        hs_valid, fifo_wr_en, out_nak_active, in_nak_active, prog_done;
    logic [1:0]  hs_code;
    logic [5:0]  tmode_oh;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    usbd_gnak_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pkt_valid(pkt_valid),
        .pkt_setup(pkt_setup), .pkt_iso(pkt_iso), .pkt_len(pkt_len),
        .fifo_space(fifo_space), .ep_nak(ep_nak), .ep_stall(ep_stall),
        .hs_valid(hs_valid), .hs_code(hs_code), .fifo_wr_en(fifo_wr_en),
        .out_nak_active(out_nak_active), .in_nak_active(in_nak_active),
        .tmode_oh(tmode_oh), .prog_done(prog_done)
    );

    // {gnak, setup, iso, stall, ep_nak, room, code[1:0], wr}
    localparam logic [8:0] VEC [0:11] = '{
        9'b0_0_0_0_0_1_01_1,
        9'b0_0_0_1_1_1_11_0,
        9'b0_0_0_0_1_1_10_0,
        9'b0_0_0_0_0_0_10_0,
        9'b0_0_1_0_0_1_00_1,
        9'b0_0_1_0_0_0_00_0,
        9'b1_0_0_0_0_1_10_0,
        9'b1_0_0_1_0_1_11_0,
        9'b1_0_1_0_0_1_00_0,
        9'b1_1_0_1_1_1_01_1,
        9'b1_1_0_0_0_0_10_0,
        9'b0_1_0_1_0_1_01_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = CTRL;
    endtask

    function automatic string vtag(input logic [8:0] v);
        if (v[7])      return "R11";
        if (v[8])      return v[6] ? "R10" : "R9";
        return "R12";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 nak", {30'd0, out_nak_active, in_nak_active}, 32'h0);
        chk("R1 tmode", {26'd0, tmode_oh}, 32'h1);
        chk("R1 prog", {31'd0, prog_done}, 32'h0);
        chk("R1 hs", {31'd0, hs_valid}, 32'h0);

        // Handshake vector table
        for (int i = 0; i < 12; i++) begin
            bus_write(CTRL, VEC[i][8] ? 32'h200 : 32'h400);
            @(negedge clk);
            pkt_valid = 1'b1;
            pkt_setup = VEC[i][7];
            pkt_iso   = VEC[i][6];
            ep_stall  = VEC[i][5];
            ep_nak    = VEC[i][4];
            pkt_len   = VEC[i][3] ? 11'd64 : 11'd65;
            @(negedge clk);
            pkt_valid = 1'b0;
            chk(vtag(VEC[i]), {29'd0, hs_valid, hs_code},
                {29'd0, 1'b1, VEC[i][2:1]});
            chk(vtag(VEC[i]), {31'd0, fifo_wr_en}, {31'd0, VEC[i][0]});
            @(negedge clk);
            chk("R8 idle", {30'd0, hs_valid, fifo_wr_en}, 32'h0);
        end
        bus_write(CTRL, 32'h400);

        // R2 / R3 global OUT NAK
        bus_write(CTRL, 32'h200);
        chk("R2 set", bus_rdata, 32'h8);
        chk("R2 out", {31'd0, out_nak_active}, 32'h1);
        bus_write(CTRL, 32'h400);
        chk("R3 clear", bus_rdata, 32'h0);
        bus_write(CTRL, 32'h600);
        chk("R3 set wins", {31'd0, out_nak_active}, 32'h1);
        bus_write(CTRL, 32'h600);
        chk("R3 set wins held", bus_rdata, 32'h8);
        bus_write(CTRL, 32'h400);

        // R4 global IN NAK
        bus_write(CTRL, 32'h080);
        chk("R4 set", bus_rdata, 32'h4);
        chk("R4 in", {31'd0, in_nak_active}, 32'h1);
        bus_write(CTRL, 32'h100);
        chk("R4 clear", bus_rdata, 32'h0);
        bus_write(CTRL, 32'h180);
        chk("R4 set wins", bus_rdata, 32'h4);
        bus_write(CTRL, 32'h100);

        // R5 reserved, status and foreign addresses
        bus_write(CTRL, 32'hFFFF_F00F);
        chk("R5 reserved", bus_rdata, 32'h0);
        bus_write(12'h808, 32'h0000_0AF0);
        chk("R5 other addr", bus_rdata, 32'h0);
        chk("R5 other state", {29'd0, out_nak_active, in_nak_active, prog_done}, 32'h0);
        bus_addr = 12'h808;
        #1;
        chk("R5 other read", bus_rdata, 32'h0);
        bus_addr = CTRL;

        // R6 test mode
        for (int c = 0; c < 8; c++) begin
            bus_write(CTRL, 32'(c) << 4);
            chk("R6 field", bus_rdata, 32'(c) << 4);
            chk("R6 onehot", {26'd0, tmode_oh},
                (c >= 1 && c <= 5) ? (32'h1 << c) : 32'h1);
        end

        // R7 programming done flag
        bus_write(CTRL, 32'h800);
        chk("R7 set", bus_rdata, 32'h800);
        chk("R7 out", {31'd0, prog_done}, 32'h1);
        bus_write(CTRL, 32'h0);
        chk("R7 clear", {31'd0, prog_done}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule